// File: doc/BRIEF.md
# TDM Frame Sync Period Checker

This block supervises the frame-alignment strobe that travels with a serial T1 or E1 time-division bit stream. For every link it keeps a free-running bit counter (position inside the frame) and a frame counter (position inside the superframe). The strobe re-anchors these counters, so a downstream channel extractor can read the current bit and frame position directly.

The expected strobe spacing is configurable. It can be one frame, so a strobe is due at every bit 0. It can also be one superframe of 12, 16 or 24 frames, so a strobe is due only at bit 0 of frame 0. A strobe that lands anywhere else raises a sticky per-link error flag. The counters of that link then re-align at once to the new strobe. A missing strobe is not an error: the counters simply keep running. Frame length, strobe spacing and superframe length are shared by all links. Each link has its own strobe input, clear strobe, error flag and position outputs, and no link's state affects another link.

Top module: `tdm_sync_chk`

## Requirements
- R1: The bit position counts 0 up to L-1 and then returns to 0, one step per clock. L is 193 when `line_e1_i`=0 and 256 when `line_e1_i`=1. The frame position advances by one each time the bit position returns to 0.
- R2: The frame position wraps to 0 after frame N-1. N is selected by `sf_sel_i`: 0 gives 12, 1 gives 16, and 2 or 3 give 24.
- R3: With `sf_mode_i`=0 (one strobe per frame), a strobe at bit position 0 sets no error. A strobe at any other bit position sets the link's error flag on the next clock.
- R4: With `sf_mode_i`=1 (one strobe per superframe), only a strobe at bit 0 of frame 0 is accepted. A strobe at any other position, including bit 0 of another frame, sets the error flag.
- R5: On the clock after any strobe, the bit position is 1. In superframe mode the frame position becomes 0. In frame mode the frame position is left unchanged.
- R6: The first strobe after reset, and the first strobe after any change of `line_e1_i`, `sf_mode_i` or `sf_sel_i`, aligns the counters without setting the error flag. A strobe in the same cycle as the change counts as that first strobe.
- R7: A missing strobe at an expected boundary sets no error, and the counters keep counting.
- R8: The error flag is sticky. It clears on the clock after `clr_i` is high for that link. If an error is detected in the same cycle as the clear, the flag stays set.
- R9: `sync_i` is sampled on the rising clock edge. Only its first high cycle is a strobe; later cycles of a held-high level have no effect.
- R10: Strobes, clears and errors on one link have no effect on the flags or positions of any other link.
- R11: After reset every bit position, frame position and error flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_e1_i | input | 1 | Frame length select: 0 = 193 bits, 1 = 256 bits |
| sf_mode_i | input | 1 | Strobe spacing: 0 = every frame, 1 = every superframe |
| sf_sel_i | input | 2 | Superframe length: 0 = 12, 1 = 16, 2 or 3 = 24 frames |
| sync_i | input | NUM_LINKS | Frame strobe, one bit per link |
| clr_i | input | NUM_LINKS | Error clear strobe, one bit per link |
| err_o | output | NUM_LINKS | Sticky misplaced-strobe flag, one bit per link |
| bit_pos_o | output | NUM_LINKS*BIT_W | Bit position per link, link 0 in the low bits |
| frame_pos_o | output | NUM_LINKS*FRM_W | Frame position per link, link 0 in the low bits |

## Verification
The bench places strobes at exact boundaries and at misplaced positions in both spacing modes. One of these is bit 0 of a non-zero frame, which a design checking only the bit counter would accept. A strobe is issued in the very cycle of a configuration change; a design that keeps its arming across the change would flag it. A level is held high for several cycles, which a design without edge detection would count as repeated misplaced strobes. A clear is issued together with a new error, so a design that gives the clear priority would drop the flag. Runs across whole 24-frame superframes without strobes catch a wrong wrap point or a spurious missing-strobe error, and a second link left idle exposes any crosstalk between links.

// File: rtl/tdmsc_pkg.sv
package tdmsc_pkg;

   typedef enum logic [1:0] {
      SFSEL_12  = 2'd0,
      SFSEL_16  = 2'd1,
      SFSEL_24  = 2'd2,
      SFSEL_24B = 2'd3
   } sf_sel_e;

   typedef struct packed {
      logic    line_e1;
      logic    sf_mode;
      sf_sel_e sf_sel;
   } tdmsc_cfg_t;

endpackage

// File: rtl/tdmsc_cfg.sv
module tdmsc_cfg
   import tdmsc_pkg::*;
#(
   parameter int T1_BITS = 193,
   parameter int E1_BITS = 256,
   parameter int SF_A    = 12,
   parameter int SF_B    = 16,
   parameter int SF_C    = 24,
   parameter int BIT_W   = 9,
   parameter int FRM_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tdmsc_cfg_t       cfg_i,
   output logic             cfg_chg_o,
   output logic             sf_mode_o,
   output logic [BIT_W-1:0] flen_o,
   output logic [FRM_W-1:0] slen_o
);

   tdmsc_cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= cfg_i;
   end

   assign cfg_chg_o = (cfg_i != cfg_q);
   assign sf_mode_o = cfg_i.sf_mode;

   always_comb begin
      flen_o = cfg_i.line_e1 ? BIT_W'(E1_BITS) : BIT_W'(T1_BITS);
      unique case (cfg_i.sf_sel)
         SFSEL_12: slen_o = FRM_W'(SF_A);
         SFSEL_16: slen_o = FRM_W'(SF_B);
         default:  slen_o = FRM_W'(SF_C);
      endcase
   end

endmodule

// File: rtl/tdmsc_pos_ctr.sv
module tdmsc_pos_ctr #(
   parameter int BIT_W = 9,
   parameter int FRM_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BIT_W-1:0] flen_i,
   input  logic [FRM_W-1:0] slen_i,
   input  logic             load_i,
   input  logic             load_frm_i,
   output logic [BIT_W-1:0] bit_o,
   output logic [FRM_W-1:0] frm_o
);

   logic [BIT_W-1:0] bit_q, bit_d;
   logic [FRM_W-1:0] frm_q, frm_d;
   logic             bit_last, frm_last;

   assign bit_last = (bit_q >= flen_i - BIT_W'(1));
   assign frm_last = (frm_q >= slen_i - FRM_W'(1));

   always_comb begin
      bit_d = bit_q;
      frm_d = frm_q;
      if (load_i) begin
         bit_d = BIT_W'(1);
         if (load_frm_i) frm_d = '0;
      end else if (bit_last) begin
         bit_d = '0;
         frm_d = frm_last ? '0 : frm_q + FRM_W'(1);
      end else begin
         bit_d = bit_q + BIT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q <= '0;
         frm_q <= '0;
      end else begin
         bit_q <= bit_d;
         frm_q <= frm_d;
      end
   end

   assign bit_o = bit_q;
   assign frm_o = frm_q;

   // R1
   bit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && bit_q == flen_i - BIT_W'(1)) |=> (bit_q == '0));

   // R5
   load_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (bit_q == BIT_W'(1)));

   // R2
   frm_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && bit_q == flen_i - BIT_W'(1) && frm_q == slen_i - FRM_W'(1))
      |=> (frm_q == '0));

   // R1
   frm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && bit_q < flen_i - BIT_W'(1)) |=> $stable(frm_q));

endmodule

// File: rtl/tdmsc_link.sv
module tdmsc_link #(
   parameter int BIT_W = 9,
   parameter int FRM_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_i,
   input  logic             clr_i,
   input  logic             cfg_chg_i,
   input  logic             sf_mode_i,
   input  logic [BIT_W-1:0] flen_i,
   input  logic [FRM_W-1:0] slen_i,
   output logic             err_o,
   output logic [BIT_W-1:0] bit_o,
   output logic [FRM_W-1:0] frm_o
);

   logic sync_q, armed_q, err_q;
   logic strobe, armed_now, at_bound, misplaced;
   logic [BIT_W-1:0] bit_pos;
   logic [FRM_W-1:0] frm_pos;

   assign strobe    = sync_i & ~sync_q;
   assign armed_now = armed_q & ~cfg_chg_i;
   assign at_bound  = (bit_pos == '0) && (!sf_mode_i || frm_pos == '0);
   assign misplaced = strobe & armed_now & ~at_bound;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q  <= 1'b0;
         armed_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         sync_q  <= sync_i;
         armed_q <= strobe | armed_now;
         err_q   <= (err_q & ~clr_i) | misplaced;
      end
   end

   tdmsc_pos_ctr #(
      .BIT_W (BIT_W),
      .FRM_W (FRM_W)
   ) u_pos (
      .clk        (clk),
      .rst_n      (rst_n),
      .flen_i     (flen_i),
      .slen_i     (slen_i),
      .load_i     (strobe),
      .load_frm_i (sf_mode_i),
      .bit_o      (bit_pos),
      .frm_o      (frm_pos)
   );

   assign err_o = err_q;
   assign bit_o = bit_pos;
   assign frm_o = frm_pos;

   // R8
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !clr_i) |=> err_q);

   // R8
   err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !sync_i) |=> !err_q);

   // R9
   held_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_i && sync_q && !clr_i) |=> (err_q == $past(err_q)));

   // R6
   first_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && !clr_i) |=> (err_q == $past(err_q)));

   // R5
   sf_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && sf_mode_i) |=> (frm_pos == '0));

endmodule

// File: rtl/tdm_sync_chk.sv
module tdm_sync_chk
   import tdmsc_pkg::*;
#(
   parameter int NUM_LINKS = 2,
   parameter int T1_BITS   = 193,
   parameter int E1_BITS   = 256,
   parameter int SF_A      = 12,
   parameter int SF_B      = 16,
   parameter int SF_C      = 24,
   localparam int MAX_BITS = (T1_BITS > E1_BITS) ? T1_BITS : E1_BITS,
   localparam int MAX_SF_AB = (SF_A > SF_B) ? SF_A : SF_B,
   localparam int MAX_SF   = (MAX_SF_AB > SF_C) ? MAX_SF_AB : SF_C,
   localparam int BIT_W    = $clog2(MAX_BITS + 1),
   localparam int FRM_W    = $clog2(MAX_SF + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       line_e1_i,
   input  logic                       sf_mode_i,
   input  logic [1:0]                 sf_sel_i,
   input  logic [NUM_LINKS-1:0]       sync_i,
   input  logic [NUM_LINKS-1:0]       clr_i,
   output logic [NUM_LINKS-1:0]       err_o,
   output logic [NUM_LINKS*BIT_W-1:0] bit_pos_o,
   output logic [NUM_LINKS*FRM_W-1:0] frame_pos_o
);

   if (NUM_LINKS < 1) begin : g_bad_links
      $error("tdm_sync_chk: NUM_LINKS must be at least 1");
   end
   if (T1_BITS < 2 || E1_BITS < 2) begin : g_bad_flen
      $error("tdm_sync_chk: frame lengths must be at least 2 bits");
   end
   if (SF_A < 2 || SF_B < 2 || SF_C < 2) begin : g_bad_sflen
      $error("tdm_sync_chk: superframe lengths must be at least 2 frames");
   end

   tdmsc_cfg_t       cfg;
   logic             cfg_chg, sf_mode;
   logic [BIT_W-1:0] flen;
   logic [FRM_W-1:0] slen;

   assign cfg.line_e1 = line_e1_i;
   assign cfg.sf_mode = sf_mode_i;
   assign cfg.sf_sel  = sf_sel_e'(sf_sel_i);

   tdmsc_cfg #(
      .T1_BITS (T1_BITS),
      .E1_BITS (E1_BITS),
      .SF_A    (SF_A),
      .SF_B    (SF_B),
      .SF_C    (SF_C),
      .BIT_W   (BIT_W),
      .FRM_W   (FRM_W)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_i     (cfg),
      .cfg_chg_o (cfg_chg),
      .sf_mode_o (sf_mode),
      .flen_o    (flen),
      .slen_o    (slen)
   );

   for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
      tdmsc_link #(
         .BIT_W (BIT_W),
         .FRM_W (FRM_W)
      ) u_link (
         .clk       (clk),
         .rst_n     (rst_n),
         .sync_i    (sync_i[i]),
         .clr_i     (clr_i[i]),
         .cfg_chg_i (cfg_chg),
         .sf_mode_i (sf_mode),
         .flen_i    (flen),
         .slen_i    (slen),
         .err_o     (err_o[i]),
         .bit_o     (bit_pos_o[i*BIT_W +: BIT_W]),
         .frm_o     (frame_pos_o[i*FRM_W +: FRM_W])
      );
   end

   // R11
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (err_o == '0));

endmodule

// File: tb/tdm_sync_chk_tb.sv
module tdm_sync_chk_tb;

   localparam int NL    = 2;
   localparam int BIT_W = 9;
   localparam int FRM_W = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_e1 = 1'b0, sf_mode = 1'b0;
   logic [1:0] sf_sel = 2'd0;
   logic [NL-1:0] sync = '0, clr = '0;
   logic [NL-1:0] err;
   logic [NL*BIT_W-1:0] bit_pos;
   logic [NL*FRM_W-1:0] frame_pos;

   always #5 clk = ~clk;

   tdm_sync_chk #(.NUM_LINKS(NL)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_e1_i   (line_e1),
      .sf_mode_i   (sf_mode),
      .sf_sel_i    (sf_sel),
      .sync_i      (sync),
      .clr_i       (clr),
      .err_o       (err),
      .bit_pos_o   (bit_pos),
      .frame_pos_o (frame_pos)
   );

   typedef struct packed {
      logic [NL-1:0]       e;
      logic [NL*BIT_W-1:0] b;
      logic [NL*FRM_W-1:0] f;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    checks = 0, errors = 0;
   bit    done = 0;

   // bench-side settings and reference state
   logic  s_e1 = 0, s_sf = 0;
   logic [1:0] s_sel = 0;
   logic  q_e1 = 0, q_sf = 0;
   logic [1:0] q_sel = 0;
   int    mb[NL], mf[NL];
   logic  me[NL], ma[NL], ms[NL];

   function automatic int flen();
      return s_e1 ? 256 : 193;
   endfunction

   function automatic int slen();
      return (s_sel == 2'd0) ? 12 : (s_sel == 2'd1) ? 16 : 24;
   endfunction

   task automatic step(input logic [NL-1:0] s, input logic [NL-1:0] c, input string tag);
      exp_t x;
      logic chg;
      @(negedge clk);
      line_e1 = s_e1; sf_mode = s_sf; sf_sel = s_sel;
      sync = s; clr = c;
      chg = (s_e1 != q_e1) || (s_sf != q_sf) || (s_sel != q_sel);
      for (int i = 0; i < NL; i++) begin
         logic pulse, arm, ok;
         pulse = s[i] && !ms[i];
         arm   = ma[i] && !chg;
         ok    = (mb[i] == 0) && (!s_sf || mf[i] == 0);
         me[i] = (me[i] && !c[i]) || (pulse && arm && !ok);
         ma[i] = pulse || arm;
         ms[i] = s[i];
         if (pulse) begin
            mb[i] = 1;
            if (s_sf) mf[i] = 0;
         end else if (mb[i] >= flen() - 1) begin
            mb[i] = 0;
            mf[i] = (mf[i] >= slen() - 1) ? 0 : mf[i] + 1;
         end else begin
            mb[i] = mb[i] + 1;
         end
         x.e[i] = me[i];
         x.b[i*BIT_W +: BIT_W] = BIT_W'(mb[i]);
         x.f[i*FRM_W +: FRM_W] = FRM_W'(mf[i]);
      end
      q_e1 = s_e1; q_sf = s_sf; q_sel = s_sel;
      exp_q.push_back(x);
      tag_q.push_back(tag);
   endtask

   // idle until link k sits at bit b (and frame f when f >= 0)
   task automatic run_to(input int k, input int b, input int f, input string tag);
      for (int n = 0; n < 20000; n++) begin
         if (mb[k] == b && (f < 0 || mf[k] == f)) return;
         step('0, '0, tag);
      end
   endtask

   // monitor: compare each result one edge after its stimulus
   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         exp_t  x;
         string t;
         x = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (x !== {err, bit_pos, frame_pos}) begin
            errors++;
            $display("FAIL %s: err=%b bit=%h frm=%h expected err=%b bit=%h frm=%h",
                     t, err, bit_pos, frame_pos, x.e, x.b, x.f);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < NL; i++) begin
         mb[i] = 0; mf[i] = 0; me[i] = 0; ma[i] = 0; ms[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R11 reset state
      checks++;
      if (err !== '0 || bit_pos !== '0 || frame_pos !== '0) begin
         errors++;
         $display("FAIL R11: err=%b bit=%h frm=%h expected all zero", err, bit_pos, frame_pos);
      end

      // R6 first strobe on both links, T1 frame mode
      step(2'b11, 2'b00, "R6 first strobe after reset");
      for (int r = 0; r < 3; r++) begin
         run_to(0, 0, -1, "R1 R7 free run");
         step(2'b01, 2'b00, "R3 aligned strobe");
      end
      // R3 R5 R10 misplaced strobe on link 0
      run_to(0, 50, -1, "R1 free run");
      step(2'b01, 2'b00, "R3 R10 misplaced strobe");
      step(2'b00, 2'b00, "R5 realigned position");
      step(2'b00, 2'b00, "R8 sticky flag");
      step(2'b00, 2'b01, "R8 clear");
      // R9 held level
      run_to(0, 0, -1, "R7 free run");
      for (int h = 0; h < 4; h++) step(2'b01, 2'b00, "R9 held level");
      step(2'b00, 2'b00, "R9 after held level");
      // R8 error with clear in the same cycle
      run_to(0, 77, -1, "R1 free run");
      step(2'b01, 2'b01, "R8 error wins over clear");
      step(2'b00, 2'b00, "R8 flag kept");
      step(2'b00, 2'b01, "R8 clear alone");
      // R10 link 1 error leaves link 0 alone
      run_to(1, 10, -1, "R7 free run");
      step(2'b10, 2'b00, "R10 link 1 misplaced");
      step(2'b00, 2'b11, "R8 clear both");

      // E1 superframe 16: strobe in cycle of change
      s_e1 = 1; s_sf = 1; s_sel = 2'd1;
      step(2'b01, 2'b00, "R6 strobe with config change");
      run_to(0, 0, 0, "R1 R2 free run");
      step(2'b01, 2'b00, "R4 aligned superframe strobe");
      run_to(0, 0, 5, "R2 R7 free run");
      step(2'b01, 2'b00, "R4 strobe at wrong frame");
      step(2'b00, 2'b01, "R5 R8 realigned and cleared");

      // superframe 24, runs over whole superframes
      s_sel = 2'd2;
      step(2'b11, 2'b00, "R6 strobe with config change");
      run_to(0, 0, 0, "R2 R7 free run");
      step(2'b01, 2'b00, "R4 aligned superframe strobe");
      run_to(0, 0, 23, "R2 free run");
      run_to(0, 0, 0, "R2 wrap at 24");
      s_sel = 2'd3;
      run_to(0, 0, 23, "R2 code 3 free run");
      run_to(0, 0, 0, "R2 code 3 wrap");

      // T1 superframe 12
      s_e1 = 0; s_sel = 2'd0;
      step(2'b00, 2'b00, "R6 config change");
      step(2'b01, 2'b00, "R6 first strobe");
      run_to(0, 0, 0, "R1 R2 free run");
      step(2'b01, 2'b00, "R4 aligned superframe strobe");
      run_to(0, 100, 3, "R2 free run");
      step(2'b01, 2'b00, "R4 misplaced superframe strobe");
      step(2'b00, 2'b00, "R5 frame reset to 0");

      // frame mode again: misplaced strobe keeps frame index
      s_sf = 0;
      step(2'b01, 2'b11, "R6 strobe with config change");
      run_to(0, 20, -1, "R1 free run");
      step(2'b01, 2'b00, "R3 R5 misplaced keeps frame");
      step(2'b00, 2'b00, "R5 frame unchanged");

      @(negedge clk);
      wait (exp_q.size() == 0);
      @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule